// File: doc/BRIEF.md
# Six-bit binary rate multiplier

This block passes a chosen fraction of its input clock pulses to its output. A six-bit synchronous counter steps through 64 states. Each state opens at most one of six gates, and each gate belongs to one rate-select bit. The select bit of weight 2^k opens its gate on 2^k states in every 64. The Z output is normally HIGH. It drops during the LOW half of the clock whenever an opened gate has its select bit set. Over every 64 clocks, Z therefore carries m low pulses, where m is the binary value of the select bus. The pulses are evenly spaced when m is a single power of two, and interleaved otherwise.

The Y output is the complement of Z and can be forced LOW by its own enable. An active-low terminal-count output marks the all-ones state while counting is enabled. No pulse is ever emitted in that state. A second instance clocked from the same clock can take that terminal count as both its count enable and its Z enable. The second counter then advances once per 64 clocks, and the pair covers a 4096-clock period with 12 bits of rate selection. The master-reset input clears the counter on a clock edge and holds it at zero. While it is held, pulses from the weight-32 gate still pass.

Top module: `rate_mult`

## Requirements
- R1: With master reset LOW, the counter advances by one, modulo 64, on each rising clock edge where count enable is LOW. It holds its value on edges where count enable is HIGH.
- R2: Terminal count is LOW exactly when the counter holds 63 and count enable is LOW. It is HIGH otherwise, and it follows count enable without waiting for a clock edge.
- R3: Master reset HIGH at a rising edge loads 0 into the counter and keeps it there. During reset, Z still pulses LOW in every LOW clock phase when Z-enable is LOW and select bit 5 is HIGH. Select bit 4 alone gives no pulse.
- R4: Z is HIGH during every HIGH clock phase. Counting from the counter's least significant bit, the gate for select bit k is open when the lowest 5-k counter bits are all 1 and the next bit is 0. Starting from state 0, the first pulse for select bit k alone therefore comes in state 2^(5-k)-1.
- R5: With counting enabled and Z-enable LOW, any 64 consecutive LOW clock phases hold exactly m LOW samples of Z, for every m from 0 to 63.
- R6: While the counter holds 63, Z stays HIGH for every select value. With all six select bits HIGH, the only pulse-free phase in 64 is the one where terminal count is LOW.
- R7: When m = 2^k, successive Z pulses are exactly 64/m clocks apart.
- R8: With Z-enable HIGH, Z stays HIGH.
- R9: With Y-enable LOW, Y equals the complement of Z at all times. With Y-enable HIGH, Y is LOW.
- R10: In a cascade, the first terminal count drives the count enable and the Z-enable of the second instance. The second instance's Z then carries m_hi pulses per 4096 clocks, and its terminal count goes LOW once per 4096 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock; its LOW phase also gates the pulses |
| cnt_en_n | input | 1 | Count enable, active LOW |
| clr | input | 1 | Master reset, active HIGH, synchronous |
| zen_n | input | 1 | Z output enable, active LOW |
| yen_n | input | 1 | Y output enable, active LOW |
| rate_sel | input | 6 | Rate select; bit k carries weight 2^k |
| term_n | output | 1 | Terminal count, active LOW |
| pulse_z_n | output | 1 | Gated pulse output, LOW while pulsing |
| pulse_y | output | 1 | Complement of Z, forced LOW when Y is disabled |

## Verification
State 63 is where the terminal count and the pulse suppression meet. The bench sets all six select bits and walks through full cycles. It then requires that the single Z-high LOW phase in each window is the same phase in which the terminal count reads LOW. The bench also freezes the counter at 63 by raising count enable during that phase. It checks that the terminal count rises at once and that Z stays quiet while the count is held. A second overlap is master reset held HIGH with select bit 5 set: the clear and the weight-32 pulse share every cycle, and the bench expects one pulse per clock with the terminal count HIGH.

// File: rtl/rm_pkg.sv
// Package: shared constants for the rate multiplier.
// Assumes a counter width of a few bits; all other sizes derive from it.
package rm_pkg;
    localparam int RM_WIDTH  = 6;
    localparam int RM_STATES = 1 << RM_WIDTH;
endpackage

// File: rtl/rm_counter.sv
// Module: rm_counter
// Synchronous binary counter with a synchronous active-high clear and an
// active-low count enable, plus an active-low terminal-count flag.
// Assumes: clear overrides the enable; the flag is combinational in the enable.
module rm_counter #(
    parameter int WIDTH = rm_pkg::RM_WIDTH
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             cnt_en_n,
    output logic [WIDTH-1:0] count_q,
    output logic             term_n
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    // Purpose: clear, advance or hold the count on each rising edge.
    always_ff @(posedge clk) begin
        if (clr) begin
            count_q <= '0;
        end else if (!cnt_en_n) begin
            count_q <= count_q + STEP;
        end
    end

    // Purpose: flag the all-ones state while counting is enabled.
    always_comb begin
        term_n = ~((&count_q) & ~cnt_en_n);
    end
endmodule

// File: rtl/rm_gate_decode.sv
// Module: rm_gate_decode
// Decodes the counter state into one gate-open line per select bit. The line
// for select bit k opens when the lowest WIDTH-1-k counter bits are all ones
// and the bit above them is zero, so bit k opens on 2^k of 2^WIDTH states.
// Assumes: at most one line is open in any state; none opens in the all-ones state.
module rm_gate_decode #(
    parameter int WIDTH = rm_pkg::RM_WIDTH
) (
    input  logic [WIDTH-1:0] count_q,
    output logic [WIDTH-1:0] gate_open
);
    // Purpose: build one decode term per select bit.
    for (genvar k = 0; k < WIDTH; k++) begin : g_gate
        localparam int J = WIDTH - 1 - k;
        if (J == 0) begin : g_top
            assign gate_open[k] = ~count_q[0];
        end else begin : g_low
            assign gate_open[k] = (&count_q[J-1:0]) & ~count_q[J];
        end
    end
endmodule

// File: rtl/rm_aoi_out.sv
// Module: rm_aoi_out
// Output stage: an AND-OR-INVERT of the opened gates, the select bits, the Z
// enable and the LOW clock phase, plus the Y output as its gated complement.
// Assumes: pulses exist only while the clock is LOW.
module rm_aoi_out #(
    parameter int WIDTH = rm_pkg::RM_WIDTH
) (
    input  logic             clk,
    input  logic             zen_n,
    input  logic             yen_n,
    input  logic [WIDTH-1:0] rate_sel,
    input  logic [WIDTH-1:0] gate_open,
    output logic             pulse_z_n,
    output logic             pulse_y
);
    logic any_gate;

    // Purpose: combine the selected and opened gates.
    always_comb begin
        any_gate = |(rate_sel & gate_open);
    end

    // Purpose: drop Z during the LOW clock phase when a gate passes.
    always_comb begin
        pulse_z_n = ~(~clk & ~zen_n & any_gate);
    end

    // Purpose: complement Z into Y, held LOW while Y is disabled.
    always_comb begin
        pulse_y = ~pulse_z_n & ~yen_n;
    end
endmodule

// File: rtl/rate_mult.sv
// Module: rate_mult
// Binary rate multiplier: gives rate_sel/2^WIDTH of the clock pulses on Z,
// with a complement on Y and a terminal count for cascading.
// Assumes: one clock; clr is a synchronous, active-high master reset.
module rate_mult #(
    parameter int WIDTH = rm_pkg::RM_WIDTH
) (
    input  logic             clk,
    input  logic             cnt_en_n,
    input  logic             clr,
    input  logic             zen_n,
    input  logic             yen_n,
    input  logic [WIDTH-1:0] rate_sel,
    output logic             term_n,
    output logic             pulse_z_n,
    output logic             pulse_y
);
    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] gate_open;

    // Purpose: state counter and terminal-count flag.
    rm_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk      (clk),
        .clr      (clr),
        .cnt_en_n (cnt_en_n),
        .count_q  (count_q),
        .term_n   (term_n)
    );

    // Purpose: per-select-bit gate decode.
    rm_gate_decode #(.WIDTH(WIDTH)) u_dec (
        .count_q   (count_q),
        .gate_open (gate_open)
    );

    // Purpose: pulse output stage.
    rm_aoi_out #(.WIDTH(WIDTH)) u_out (
        .clk       (clk),
        .zen_n     (zen_n),
        .yen_n     (yen_n),
        .rate_sel  (rate_sel),
        .gate_open (gate_open),
        .pulse_z_n (pulse_z_n),
        .pulse_y   (pulse_y)
    );
endmodule

// File: rtl/rm_checker.sv
// Module: rm_checker
// Temporal checks on the rate multiplier, attached to every instance by bind.
// At a rising edge, sampled outputs reflect the LOW phase just ended.
module rm_checker #(
    parameter int WIDTH = rm_pkg::RM_WIDTH
) (
    input logic             clk,
    input logic             clr,
    input logic             cnt_en_n,
    input logic             zen_n,
    input logic             yen_n,
    input logic [WIDTH-1:0] count_q,
    input logic             term_n,
    input logic             pulse_z_n,
    input logic             pulse_y
);
    localparam logic [WIDTH-1:0] MAXV = '1;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (clr)
        !cnt_en_n |=> count_q == WIDTH'($past(count_q) + 1'b1)); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (clr)
        cnt_en_n |=> $stable(count_q)); // R1
    AST_TC_WRAP: assert property (@(posedge clk) disable iff (clr)
        !term_n |=> count_q == '0); // R2
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (clr)
        $fell(clr) |-> count_q == '0); // R3
    AST_Z_HIGH_PHASE: assert property (@(negedge clk) disable iff (clr)
        pulse_z_n); // R4
    AST_NO_PULSE_MAX: assert property (@(posedge clk) disable iff (clr)
        count_q == MAXV |-> pulse_z_n); // R6
    AST_Z_DISABLED: assert property (@(posedge clk) disable iff (clr)
        zen_n |-> pulse_z_n); // R8
    AST_Y_DISABLED: assert property (@(posedge clk) disable iff (clr)
        yen_n |-> !pulse_y); // R9
    AST_Y_COMPL: assert property (@(posedge clk) disable iff (clr)
        !yen_n |-> pulse_y == !pulse_z_n); // R9
endmodule

bind rate_mult rm_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .clr       (clr),
    .cnt_en_n  (cnt_en_n),
    .zen_n     (zen_n),
    .yen_n     (yen_n),
    .count_q   (count_q),
    .term_n    (term_n),
    .pulse_z_n (pulse_z_n),
    .pulse_y   (pulse_y)
);

// File: tb/sim_rate_mult.sv
module sim_rate_mult;
    localparam int PERIOD = 10;
    localparam int W      = 6;
    localparam int NST    = 1 << W;

    logic clk = 1'b0;
    logic cnt_en_n = 1'b0, clr = 1'b1, zen_n = 1'b0, yen_n = 1'b0;
    logic [W-1:0] rate_sel = '0;
    logic term_n, pulse_z_n, pulse_y;

    logic clr_c = 1'b1;
    logic tc_a, z_a, y_a, tc_b, z_b, y_b;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    rate_mult #(.WIDTH(W)) u0 (
        .clk(clk), .cnt_en_n(cnt_en_n), .clr(clr), .zen_n(zen_n), .yen_n(yen_n),
        .rate_sel(rate_sel), .term_n(term_n), .pulse_z_n(pulse_z_n), .pulse_y(pulse_y));

    rate_mult #(.WIDTH(W)) u_lo (
        .clk(clk), .cnt_en_n(1'b0), .clr(clr_c), .zen_n(1'b0), .yen_n(1'b0),
        .rate_sel(6'd0), .term_n(tc_a), .pulse_z_n(z_a), .pulse_y(y_a));

    rate_mult #(.WIDTH(W)) u_hi (
        .clk(clk), .cnt_en_n(tc_a), .clr(clr_c), .zen_n(tc_a), .yen_n(1'b0),
        .rate_sel(6'd5), .term_n(tc_b), .pulse_z_n(z_b), .pulse_y(y_b));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic at_low();
        @(negedge clk); #2;
    endtask

    task automatic at_drive();
        @(posedge clk); #1;
    endtask

    // After return, the next LOW phase shows state 0, then 1, 2, ...
    task automatic restart();
        at_drive(); clr = 1'b1;
        at_drive(); clr = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int cnt, first, ylow_bad;
        repeat (3) @(posedge clk);

        // R3: clear held, bit 5 pulses every clock, bit 4 never
        at_drive(); rate_sel = 6'd32;
        cnt = 0;
        for (int i = 0; i < 4; i++) begin at_low(); if (!pulse_z_n) cnt++; end
        check(cnt == 4, "R3 bit5 pulses under clear", cnt, 4);
        check(term_n == 1'b1, "R3 reset state term_n", term_n, 1);
        at_drive(); rate_sel = 6'd16;
        cnt = 0;
        for (int i = 0; i < 4; i++) begin at_low(); if (!pulse_z_n) cnt++; end
        check(cnt == 0, "R3 bit4 silent under clear", cnt, 0);

        // R1 R2: after release term_n low first and only at state 63
        rate_sel = 6'd0;
        at_drive(); clr = 1'b0;
        first = -1; cnt = 0;
        for (int i = 0; i < NST; i++) begin
            at_low();
            if (!term_n) begin cnt++; if (first < 0) first = i; end
        end
        check(first == 63, "R1 first terminal state", first, 63);
        check(cnt == 1, "R2 terminal once per cycle", cnt, 1);

        // R1 R2 R6: freeze at 63 with count enable high
        at_drive(); rate_sel = 6'd63;
        cnt = 0;
        for (int i = 0; i < 70 && cnt == 0; i++) begin at_low(); if (!term_n) cnt = 1; end
        cnt_en_n = 1'b1; #1;
        check(term_n == 1'b1, "R2 term_n follows enable", term_n, 1);
        cnt = 0;
        for (int i = 0; i < 5; i++) begin
            at_low();
            if (!pulse_z_n || !term_n) cnt++;
        end
        check(cnt == 0, "R6 held at 63 no pulse", cnt, 0);
        cnt_en_n = 1'b0; #1;
        check(term_n == 1'b0, "R1 count held at 63", term_n, 0);

        // R4: first pulse state per select bit
        for (int k = 0; k < W; k++) begin
            int j, exp_s;
            j = W - 1 - k;
            exp_s = (1 << j) - 1;
            restart(); rate_sel = 6'(1 << k);
            first = -1;
            for (int i = 0; i < NST; i++) begin
                at_low();
                if (!pulse_z_n && first < 0) first = i;
            end
            check(first == exp_s, $sformatf("R4 first pulse bit%0d", k), first, exp_s);
        end

        // R5 R9: sweep every m over 64 LOW phases
        ylow_bad = 0;
        for (int m = 0; m < NST; m++) begin
            at_drive(); rate_sel = 6'(m);
            cnt = 0;
            for (int i = 0; i < NST; i++) begin
                at_low();
                if (!pulse_z_n) cnt++;
                if (pulse_y != ~pulse_z_n) ylow_bad++;
            end
            check(cnt == m, $sformatf("R5 pulse count m=%0d", m), cnt, m);
        end
        check(ylow_bad == 0, "R9 Y complements Z", ylow_bad, 0);

        // R4: Z high during HIGH phases, all bits selected
        cnt = 0;
        for (int i = 0; i < NST; i++) begin
            @(posedge clk); #2;
            if (!pulse_z_n) cnt++;
        end
        check(cnt == 0, "R4 no pulse in high phase", cnt, 0);

        // R6: the quiet phase coincides with terminal count
        begin
            int quiet, quiet_tc;
            quiet = 0; quiet_tc = 0;
            for (int i = 0; i < NST; i++) begin
                at_low();
                if (pulse_z_n) begin quiet++; if (!term_n) quiet_tc++; end
            end
            check(quiet == 1, "R6 one quiet phase", quiet, 1);
            check(quiet_tc == 1, "R6 quiet phase at terminal", quiet_tc, 1);
        end

        // R7: even spacing for powers of two
        for (int k = 0; k < W; k++) begin
            int last, gap_bad, gap;
            gap = NST >> k;
            at_drive(); rate_sel = 6'(1 << k);
            last = -1; gap_bad = 0;
            for (int i = 0; i < 2 * NST; i++) begin
                at_low();
                if (!pulse_z_n) begin
                    if (last >= 0 && i - last != gap) gap_bad++;
                    last = i;
                end
            end
            check(gap_bad == 0, $sformatf("R7 spacing bit%0d", k), gap_bad, 0);
        end

        // R8: Z disabled
        at_drive(); rate_sel = 6'd63; zen_n = 1'b1;
        cnt = 0;
        for (int i = 0; i < NST; i++) begin at_low(); if (!pulse_z_n || pulse_y) cnt++; end
        check(cnt == 0, "R8 Z held high", cnt, 0);
        at_drive(); zen_n = 1'b0;

        // R9: Y disabled
        at_drive(); yen_n = 1'b1;
        cnt = 0; first = 0;
        for (int i = 0; i < NST; i++) begin
            at_low();
            if (pulse_y) cnt++;
            if (!pulse_z_n) first++;
        end
        check(cnt == 0, "R9 Y held low", cnt, 0);
        check(first == 63, "R9 Z unaffected by Y enable", first, 63);
        at_drive(); yen_n = 1'b0;

        // R10: cascade over 4096 clocks
        at_drive(); clr_c = 1'b0;
        begin
            int zc, tcc;
            zc = 0; tcc = 0;
            for (int i = 0; i < NST * NST; i++) begin
                at_low();
                if (!z_b) zc++;
                if (!tc_b) tcc++;
            end
            check(zc == 5, "R10 cascade pulses", zc, 5);
            check(tcc == 1, "R10 cascade period", tcc, 1);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule